// File: doc/BRIEF.md
# Difference-of-Means Trace Accumulator

This block collects power-measurement traces for a difference-of-means side-channel analysis. Each trace is a stream of sample beats (valid, ready, last-of-trace) with a selection value supplied next to the samples. A selection computed elsewhere decides whether the whole trace goes into bin 0, goes into bin 1, or is thrown away. Both bins hold one running sum for each sample position.

A campaign begins with a start pulse. The pulse clears both bins and the three trace counters, and it captures the trace target and the selection mode. In single-bit mode only bit 0 of the selection matters. In multi-bit mode only an all-zeros or all-ones selection is binned. When the number of binned traces reaches the target, the block stops taking samples. It then streams the signed per-position difference bin 0 minus bin 1, one position per cycle, and pulses `done` afterwards. The division that turns sums into averages is left to the consumer, which can use the two bin counts for it.

Top module: `dom_trace_accum`

## Requirements
- R1: While reset is held and after it is released, `s_ready`, `m_valid` and `done` are low and all three counters read zero until a campaign is started.
- R2: A `start` pulse clears both bins and all counters, captures `target_traces` and `multi_mode`, and raises `s_ready` from the next cycle.
- R3: In multi-bit mode, a trace whose selection is all zeros is added to bin 0 and one whose selection is all ones is added to bin 1. The selection is taken from the first beat of the trace, and `s_sel` on later beats is ignored.
- R4: In multi-bit mode, any other selection value discards the whole trace and increments `drop_count` at its last beat. A discarded trace changes neither bin.
- R5: In single-bit mode, `s_sel[0]` = 0 selects bin 0 and `s_sel[0]` = 1 selects bin 1, whatever the upper selection bits are.
- R6: Beat k of a trace (k counted from 0) adds its unsigned sample into position k of the chosen bin. Beats after position DEPTH-1, up to and including the last beat, are ignored. Positions that a short trace does not reach are left unchanged.
- R7: When the last beat of a binned trace brings bin0_count + bin1_count up to the target (a target of 0 counts as 1), `s_ready` goes low from the next cycle. The block then streams DEPTH beats with `m_index` 0 to DEPTH-1 in order, one per cycle. Each `m_data` is the signed value bin0[k] − bin1[k], and `m_last` marks index DEPTH-1.
- R8: `done` is high for exactly the one cycle after the `m_last` beat. The block then stays idle with `s_ready` low until the next `start`.
- R9: Outside a running campaign, the three counters hold their values until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a new campaign (clears bins and counters) |
| multi_mode | input | 1 | 1: multi-bit selection, 0: single-bit selection (captured at start) |
| target_traces | input | CNT_W | Number of binned traces to collect (captured at start) |
| s_valid | input | 1 | Sample beat valid |
| s_ready | output | 1 | Block accepts sample beats |
| s_data | input | SAMPLE_W | Unsigned sample value |
| s_sel | input | SEL_W | Selection value, used on the first beat of a trace |
| s_last | input | 1 | Final beat of the current trace |
| m_valid | output | 1 | Difference beat valid |
| m_index | output | AW | Sample position of the difference beat |
| m_data | output | DIFF_W | Signed difference bin0 − bin1 |
| m_last | output | 1 | Final difference beat |
| done | output | 1 | One-cycle pulse after the final difference beat |
| bin0_count | output | CNT_W | Traces added to bin 0 |
| bin1_count | output | CNT_W | Traces added to bin 1 |
| drop_count | output | CNT_W | Traces discarded |

## Verification
Two things happen on the same clock edge: the last beat of the closing trace is added into its bin, and the block switches from collecting to streaming. If the switch wins, the final sample is lost. The bench makes the final trace of every campaign the one that reaches the target, and it compares each streamed position with a model that includes that final beat. It also checks that `s_ready` is already low on the first streamed beat. A restart raised during a partly filled campaign is a second overlap: clearing and accumulation meet there, and the later differences must show none of the earlier trace.

// File: rtl/dom_pkg.sv
// Shared types for the difference-of-means trace accumulator.
// Assumes nothing beyond the 2017 language standard.
package dom_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_DUMP
    } dom_state_e;

    typedef enum logic [1:0] {
        CLS_BIN0,
        CLS_BIN1,
        CLS_DROP
    } dom_class_e;
endpackage

// File: rtl/dom_classifier.sv
// Maps a selection value to bin 0, bin 1 or discard.
// Single-bit mode looks at bit 0 only; multi-bit mode bins only uniform values.
module dom_classifier
    import dom_pkg::*;
#(
    parameter int SEL_W = 4
) (
    input  logic [SEL_W-1:0] sel,
    input  logic             multi,
    output dom_class_e       cls
);
    // Purpose: decide the bin of a trace from its selection value.
    always_comb begin
        if (!multi) begin
            cls = sel[0] ? CLS_BIN1 : CLS_BIN0;
        end else if (sel == '0) begin
            cls = CLS_BIN0;
        end else if (sel == '1) begin
            cls = CLS_BIN1;
        end else begin
            cls = CLS_DROP;
        end
    end
endmodule

// File: rtl/dom_bin_array.sv
// One bin: a row of DEPTH unsigned running sums with a single shared adder.
// Assumes add_idx and rd_idx stay below DEPTH; clear has priority over add.
module dom_bin_array #(
    parameter int DEPTH = 16,
    parameter int IN_W  = 8,
    parameter int ACC_W = 20,
    parameter int AW    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             add_en,
    input  logic [AW-1:0]    add_idx,
    input  logic [IN_W-1:0]  add_val,
    input  logic [AW-1:0]    rd_idx,
    output logic [ACC_W-1:0] rd_data
);
    logic [ACC_W-1:0] acc_q [DEPTH];
    logic [ACC_W-1:0] sum;

    // Purpose: one adder serves whichever position the beat targets.
    always_comb sum = acc_q[add_idx] + ACC_W'(add_val);

    // Purpose: read port for the difference stream.
    always_comb rd_data = acc_q[rd_idx];

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        // Purpose: hold, clear or update position i.
        always_ff @(posedge clk) begin
            if (!rst_n || clear) begin
                acc_q[i] <= '0;
            end else if (add_en && add_idx == AW'(i)) begin
                acc_q[i] <= sum;
            end
        end
    end
endmodule

// File: rtl/dom_ctrl.sv
// Campaign sequencer: beat position tracking, per-trace class latch,
// trace counters, target detection and the difference read-out sweep.
// Assumes the classifier is fed the current s_sel and the latched mode.
module dom_ctrl
    import dom_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CNT_W = 12,
    parameter int AW    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             multi_mode,
    input  logic [CNT_W-1:0] target_traces,
    input  logic             s_valid,
    input  logic             s_last,
    input  dom_class_e       cls_now,
    output logic             multi_q,
    output logic             s_ready,
    output logic             clear,
    output logic             add0_en,
    output logic             add1_en,
    output logic [AW-1:0]    add_idx,
    output logic [AW-1:0]    rd_idx,
    output logic             m_valid,
    output logic             m_last,
    output logic             done,
    output logic [CNT_W-1:0] bin0_count,
    output logic [CNT_W-1:0] bin1_count,
    output logic [CNT_W-1:0] drop_count
);
    localparam logic [AW-1:0] LAST_POS = AW'(DEPTH - 1);

    dom_state_e       state_q;
    logic [AW-1:0]    pos_q;
    logic [AW-1:0]    rd_q;
    logic             mid_q;
    logic             ovr_q;
    dom_class_e       cls_q;
    dom_class_e       cls_use;
    logic [CNT_W-1:0] tgt_q;
    logic [CNT_W-1:0] n0_q;
    logic [CNT_W-1:0] n1_q;
    logic [CNT_W-1:0] nd_q;
    logic [CNT_W:0]   binned_next;
    logic [CNT_W:0]   tgt_eff;
    logic             beat;
    logic             finish;

    // Purpose: handshake, class selection and bin write strobes.
    always_comb begin
        s_ready     = (state_q == ST_RUN);
        beat        = s_valid && s_ready;
        cls_use     = mid_q ? cls_q : cls_now;
        add0_en     = beat && !ovr_q && (cls_use == CLS_BIN0);
        add1_en     = beat && !ovr_q && (cls_use == CLS_BIN1);
        add_idx     = pos_q;
        clear       = start;
        binned_next = {1'b0, n0_q} + {1'b0, n1_q} + 1'b1;
        tgt_eff     = (tgt_q == '0) ? (CNT_W + 1)'(1) : {1'b0, tgt_q};
        finish      = beat && s_last && (cls_use != CLS_DROP) && (binned_next >= tgt_eff);
        rd_idx      = rd_q;
        m_valid     = (state_q == ST_DUMP);
        m_last      = m_valid && (rd_q == LAST_POS);
        bin0_count  = n0_q;
        bin1_count  = n1_q;
        drop_count  = nd_q;
    end

    // Purpose: campaign state, trace position and counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pos_q   <= '0;
            rd_q    <= '0;
            mid_q   <= 1'b0;
            ovr_q   <= 1'b0;
            cls_q   <= CLS_DROP;
            tgt_q   <= '0;
            multi_q <= 1'b0;
            n0_q    <= '0;
            n1_q    <= '0;
            nd_q    <= '0;
            done    <= 1'b0;
        end else if (start) begin
            state_q <= ST_RUN;
            pos_q   <= '0;
            rd_q    <= '0;
            mid_q   <= 1'b0;
            ovr_q   <= 1'b0;
            tgt_q   <= target_traces;
            multi_q <= multi_mode;
            n0_q    <= '0;
            n1_q    <= '0;
            nd_q    <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state_q)
                ST_RUN: begin
                    if (beat) begin
                        if (s_last) begin
                            pos_q <= '0;
                            mid_q <= 1'b0;
                            ovr_q <= 1'b0;
                            case (cls_use)
                                CLS_BIN0: n0_q <= n0_q + 1'b1;
                                CLS_BIN1: n1_q <= n1_q + 1'b1;
                                default:  nd_q <= nd_q + 1'b1;
                            endcase
                            if (finish) begin
                                state_q <= ST_DUMP;
                                rd_q    <= '0;
                            end
                        end else begin
                            mid_q <= 1'b1;
                            cls_q <= cls_use;
                            if (pos_q == LAST_POS) begin
                                ovr_q <= 1'b1;
                            end else if (!ovr_q) begin
                                pos_q <= pos_q + 1'b1;
                            end
                        end
                    end
                end
                ST_DUMP: begin
                    if (rd_q == LAST_POS) begin
                        state_q <= ST_IDLE;
                        done    <= 1'b1;
                    end else begin
                        rd_q <= rd_q + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/dom_trace_accum.sv
// Top of the difference-of-means trace accumulator. Bins sample streams by
// selection value and streams bin0 - bin1 per position once enough traces
// are binned. Assumes unsigned samples and at most one trace in flight.
module dom_trace_accum
    import dom_pkg::*;
#(
    parameter int SAMPLE_W = 8,
    parameter int SEL_W    = 4,
    parameter int DEPTH    = 16,
    parameter int CNT_W    = 12,
    localparam int AW      = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int ACC_W   = SAMPLE_W + CNT_W,
    localparam int DIFF_W  = ACC_W + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic                     multi_mode,
    input  logic [CNT_W-1:0]         target_traces,
    input  logic                     s_valid,
    output logic                     s_ready,
    input  logic [SAMPLE_W-1:0]      s_data,
    input  logic [SEL_W-1:0]         s_sel,
    input  logic                     s_last,
    output logic                     m_valid,
    output logic [AW-1:0]            m_index,
    output logic signed [DIFF_W-1:0] m_data,
    output logic                     m_last,
    output logic                     done,
    output logic [CNT_W-1:0]         bin0_count,
    output logic [CNT_W-1:0]         bin1_count,
    output logic [CNT_W-1:0]         drop_count
);
    dom_class_e       cls_now;
    logic             multi_q;
    logic             clear;
    logic             add_en [2];
    logic [AW-1:0]    add_idx;
    logic [AW-1:0]    rd_idx;
    logic [ACC_W-1:0] rd_data [2];

    dom_classifier #(.SEL_W(SEL_W)) u_cls (
        .sel   (s_sel),
        .multi (multi_q),
        .cls   (cls_now)
    );

    dom_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W), .AW(AW)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (start),
        .multi_mode    (multi_mode),
        .target_traces (target_traces),
        .s_valid       (s_valid),
        .s_last        (s_last),
        .cls_now       (cls_now),
        .multi_q       (multi_q),
        .s_ready       (s_ready),
        .clear         (clear),
        .add0_en       (add_en[0]),
        .add1_en       (add_en[1]),
        .add_idx       (add_idx),
        .rd_idx        (rd_idx),
        .m_valid       (m_valid),
        .m_last        (m_last),
        .done          (done),
        .bin0_count    (bin0_count),
        .bin1_count    (bin1_count),
        .drop_count    (drop_count)
    );

    for (genvar b = 0; b < 2; b++) begin : g_bin
        dom_bin_array #(.DEPTH(DEPTH), .IN_W(SAMPLE_W), .ACC_W(ACC_W), .AW(AW)) u_bin (
            .clk     (clk),
            .rst_n   (rst_n),
            .clear   (clear),
            .add_en  (add_en[b]),
            .add_idx (add_idx),
            .add_val (s_data),
            .rd_idx  (rd_idx),
            .rd_data (rd_data[b])
        );
    end

    // Purpose: signed difference of the two bins at the read position.
    always_comb begin
        m_index = rd_idx;
        m_data  = $signed({1'b0, rd_data[0]}) - $signed({1'b0, rd_data[1]});
    end
endmodule

// File: rtl/dom_trace_accum_chk.sv
// Property checker for dom_trace_accum, attached by bind below.
// Assumes it sees the top-level ports only.
module dom_trace_accum_chk #(
    parameter int CNT_W = 12,
    parameter int AW    = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             s_ready,
    input logic             m_valid,
    input logic [AW-1:0]    m_index,
    input logic             m_last,
    input logic             done,
    input logic [CNT_W-1:0] bin0_count,
    input logic [CNT_W-1:0] bin1_count,
    input logic [CNT_W-1:0] drop_count
);
    // R7
    dump_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid |-> !s_ready);

    // R7
    dump_begin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(m_valid) |-> (m_index == '0));

    // R7
    dump_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_last && !start) |=> (m_valid && m_index == AW'($past(m_index) + 1'b1)));

    // R8
    done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && m_last && !start) |=> (done && !m_valid && !s_ready));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2
    start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (bin0_count == '0 && bin1_count == '0 && drop_count == '0 && s_ready));

    // R9
    counts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_ready && !start) |=> ($stable(bin0_count) && $stable(bin1_count) && $stable(drop_count)));
endmodule

bind dom_trace_accum dom_trace_accum_chk #(.CNT_W(CNT_W), .AW(AW)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .s_ready    (s_ready),
    .m_valid    (m_valid),
    .m_index    (m_index),
    .m_last     (m_last),
    .done       (done),
    .bin0_count (bin0_count),
    .bin1_count (bin1_count),
    .drop_count (drop_count)
);

// File: tb/dom_trace_accum_tb_top.sv
// Scoreboard bench: the driver models the bins and queues expected
// differences; a monitor pops and compares them as the design streams.
module dom_trace_accum_tb_top;
    localparam int SW    = 8;
    localparam int SELW  = 4;
    localparam int DEPTH = 16;
    localparam int CNTW  = 12;
    localparam int AW    = 4;
    localparam int DW    = SW + CNTW + 1;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 start = 1'b0;
    logic                 multi_mode = 1'b0;
    logic [CNTW-1:0]      target_traces = '0;
    logic                 s_valid = 1'b0;
    logic                 s_ready;
    logic [SW-1:0]        s_data = '0;
    logic [SELW-1:0]      s_sel = '0;
    logic                 s_last = 1'b0;
    logic                 m_valid;
    logic [AW-1:0]        m_index;
    logic signed [DW-1:0] m_data;
    logic                 m_last;
    logic                 done;
    logic [CNTW-1:0]      bin0_count, bin1_count, drop_count;

    always #10 clk = ~clk;

    dom_trace_accum #(.SAMPLE_W(SW), .SEL_W(SELW), .DEPTH(DEPTH), .CNT_W(CNTW)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .multi_mode(multi_mode),
        .target_traces(target_traces), .s_valid(s_valid), .s_ready(s_ready),
        .s_data(s_data), .s_sel(s_sel), .s_last(s_last), .m_valid(m_valid),
        .m_index(m_index), .m_data(m_data), .m_last(m_last), .done(done),
        .bin0_count(bin0_count), .bin1_count(bin1_count), .drop_count(drop_count)
    );

    int total = 0;
    int bad = 0;
    int ref0 [DEPTH];
    int ref1 [DEPTH];
    int n0, n1, nd, tgt_m;
    bit mode_m;
    int exp_q [$];
    int mon_idx = 0;
    bit done_expect = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic end_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    task automatic begin_campaign(input bit multi, input int tgt);
        @(negedge clk);
        start = 1'b1;
        multi_mode = multi;
        target_traces = CNTW'(tgt);
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            ref0[i] = 0;
            ref1[i] = 0;
        end
        n0 = 0; n1 = 0; nd = 0;
        tgt_m = (tgt == 0) ? 1 : tgt;
        mode_m = multi;
        // R2: counters cleared and samples accepted right after start
        chk(s_ready == 1'b1, "R2 ready", int'(s_ready), 1);
        chk(bin0_count == 0 && bin1_count == 0 && drop_count == 0, "R2 counts",
            int'(bin0_count) + int'(bin1_count) + int'(drop_count), 0);
    endtask

    task automatic send_trace(input int sel, input int nbeats, input int base, input int step);
        int cls;
        if (!mode_m) cls = sel & 1;
        else if (sel == 0) cls = 0;
        else if (sel == (1 << SELW) - 1) cls = 1;
        else cls = 2;
        for (int k = 0; k < nbeats; k++) begin
            int v;
            @(negedge clk);
            while (!s_ready) @(negedge clk);
            v = (base + k * step) & ((1 << SW) - 1);
            s_valid = 1'b1;
            s_data = SW'(v);
            s_sel = (k == 0) ? SELW'(sel) : SELW'(sel ^ (k * 5));
            s_last = (k == nbeats - 1);
            if (k < DEPTH) begin
                if (cls == 0) ref0[k] += v;
                else if (cls == 1) ref1[k] += v;
            end
        end
        @(negedge clk);
        s_valid = 1'b0;
        s_last = 1'b0;
        if (cls == 0) n0++;
        else if (cls == 1) n1++;
        else nd++;
        if (cls != 2 && n0 + n1 == tgt_m) begin
            for (int i = 0; i < DEPTH; i++) exp_q.push_back(ref0[i] - ref1[i]);
        end
    endtask

    task automatic wait_done(input string req);
        while (!done) @(negedge clk);
        chk(exp_q.size() == 0, {req, " all positions streamed"}, exp_q.size(), 0);
        chk(int'(bin0_count) == n0, {req, " bin0_count"}, int'(bin0_count), n0);
        chk(int'(bin1_count) == n1, {req, " bin1_count"}, int'(bin1_count), n1);
        chk(int'(drop_count) == nd, {req, " drop_count"}, int'(drop_count), nd);
        repeat (3) @(negedge clk);
        // R8 idle afterwards, R9 counters held
        chk(s_ready == 1'b0 && m_valid == 1'b0, "R8 idle", int'(s_ready) + int'(m_valid), 0);
        chk(int'(bin0_count) == n0 && int'(bin1_count) == n1 && int'(drop_count) == nd,
            "R9 hold", int'(bin0_count), n0);
    endtask

    // Monitor: compare streamed differences against the scoreboard queue.
    always @(negedge clk) begin
        if (rst_n) begin
            if (done_expect) begin
                chk(done == 1'b1, "R8 done pulse", int'(done), 1);
                done_expect = 1'b0;
            end
            if (m_valid) begin
                chk(s_ready == 1'b0, "R7 stalled during stream", int'(s_ready), 0);
                chk(int'(m_index) == mon_idx, "R7 index order", int'(m_index), mon_idx);
                chk(m_last == (mon_idx == DEPTH - 1), "R7 last flag", int'(m_last), int'(mon_idx == DEPTH - 1));
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R7 unexpected beat", int'(m_data), 0);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    chk(int'(m_data) == e, "R7 difference", int'(m_data), e);
                end
                if (m_last) begin
                    done_expect = 1'b1;
                    mon_idx = 0;
                end else begin
                    mon_idx++;
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL R8 watchdog expired actual=0 expected=1");
        end_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: state while reset held
        chk(s_ready == 1'b0 && m_valid == 1'b0 && done == 1'b0, "R1 in reset",
            int'(s_ready) + int'(m_valid) + int'(done), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(s_ready == 1'b0 && m_valid == 1'b0 && done == 1'b0, "R1 after reset",
            int'(s_ready) + int'(m_valid) + int'(done), 0);
        chk(bin0_count == 0 && bin1_count == 0 && drop_count == 0, "R1 counts",
            int'(bin0_count) + int'(bin1_count) + int'(drop_count), 0);

        // R3, R4: multi-bit campaign, target 3, two discarded traces
        begin_campaign(1'b1, 3);
        send_trace(0, DEPTH, 10, 3);
        send_trace(15, DEPTH, 200, 1);
        send_trace(5, DEPTH, 7, 7);
        send_trace(9, DEPTH, 90, 13);
        send_trace(0, DEPTH, 50, 2);
        wait_done("R3 R4");

        // R5, R6: single-bit campaign, overlong and short traces
        begin_campaign(1'b0, 2);
        send_trace(14, DEPTH + 4, 3, 11);
        send_trace(1, 5, 120, 9);
        wait_done("R5 R6");

        // R2: restart mid-campaign, target 0 treated as 1
        begin_campaign(1'b1, 2);
        send_trace(0, DEPTH, 100, 1);
        begin_campaign(1'b1, 0);
        send_trace(15, DEPTH, 30, 5);
        wait_done("R2 R7");

        end_run();
    end
endmodule